// File: doc/BRIEF.md
# Section Address Translator with Lookaside Buffer

This block turns a 32-bit virtual address into a physical address through a one-level translation table in memory. Every table entry covers one megabyte. A requester presents an address and a read/write flag and holds them until the block raises `req_ready`. On that cycle the block returns the physical address, the attribute fields of the entry (domain, access-permission bits, cacheable and bufferable flags) and a fault code.

The most recent section translations are kept in a small, fully associative lookaside buffer. The buffer is tagged by the upper twelve address bits and replaces its entries in round-robin order. A hit completes without any memory traffic. A miss issues one word read to the table and waits for it, however many cycles it takes. The descriptor that comes back is decoded and, when it is a section, written into the buffer.

Software keeps the buffer consistent with the table through two commands. One clears the whole buffer. The other drops only the entry that covers a given virtual address.

Top module: `sec_xlate`

## Requirements
- R1: After reset `req_ready` and `mem_rd_req` are low and the buffer holds no valid entry, so the first request for any section walks the table.
- R2: The descriptor fetch address is `ttb_base[17:0]` (the table base, physical bits 31..14) followed by VA[31:20] and two zero bits.
- R3: A descriptor whose bits [1:0] are 2'b10 is a section. The physical address is descriptor[31:20] followed by VA[19:0]. `rsp_ap` is descriptor[11:10], `rsp_domain` is [8:5], `rsp_c` is [3] and `rsp_b` is [2]. `rsp_fault` is 2'b00.
- R4: A descriptor with bits [1:0] = 2'b00 returns `rsp_fault` = 2'b01, and the address and attributes are all zero. It is not cached, so asking again walks again.
- R5: A descriptor with bits [1:0] = 2'b01 or 2'b11 returns `rsp_fault` = 2'b10, and the address and attributes are all zero. It is not cached.
- R6: `req_ready` is high for exactly one cycle per accepted request, and `rsp_write` repeats that request's `req_write`. During a walk, `mem_rd_req` and `mem_rd_addr` stay steady until the cycle in which `mem_rd_valid` is high.
- R7: A request whose section is in the buffer makes no memory read. `req_ready` rises in the cycle after acceptance, and the results equal those of the walk that filled the entry.
- R8: The buffer has `TLB_ENTRIES` (default 8) entries filled in round-robin order. After eight consecutive fills, the ninth fill evicts the first of them, and the second one still hits.
- R9: `inv_all` empties the whole buffer at the next clock edge.
- R10: `inv_va_en` removes only the entry whose tag equals `inv_va[31:20]`. Other entries keep hitting.
- R11: A fill that lands in the same cycle as `inv_all`, or as an `inv_va_en` whose tag matches it, is discarded. The translation is still returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, held until `req_ready` |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access direction of the request, 1 = write |
| req_ready | output | 1 | One-cycle completion strobe; response fields valid |
| ttb_base | input | 18 | Translation table base, physical bits 31..14 |
| inv_all | input | 1 | Invalidate every buffer entry |
| inv_va_en | input | 1 | Invalidate the entry covering `inv_va` |
| inv_va | input | 32 | Address for single-entry invalidation |
| mem_rd_req | output | 1 | Descriptor read request, held until `mem_rd_valid` |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_valid | input | 1 | Descriptor read data valid |
| mem_rd_data | input | 32 | Descriptor word |
| rsp_pa | output | 32 | Physical address |
| rsp_domain | output | 4 | Domain field |
| rsp_ap | output | 2 | Access-permission field |
| rsp_c | output | 1 | Cacheable flag |
| rsp_b | output | 1 | Bufferable flag |
| rsp_fault | output | 2 | 00 none, 01 translation fault, 10 unsupported type |
| rsp_write | output | 1 | Echo of the accepted `req_write` |

## Verification
A wrong valid bit or tag in the buffer shows at the ports on the very next request for that section. A stale entry hides the expected `mem_rd_req`. A lost entry produces a read where none was due. A wrong replacement pointer stays hidden until the ninth distinct fill, so the bench runs that sequence on purpose and then probes both the evicted section and a surviving one. Decode errors in the descriptor fields show up at `req_ready` in the same response that follows the read.

// File: rtl/sxl_pkg.sv
package sxl_pkg;

  localparam int SEC_TAG_W = 12;
  localparam int SEC_OFF_W = 20;

  localparam logic [1:0] DESC_EMPTY   = 2'b00;
  localparam logic [1:0] DESC_SECTION = 2'b10;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_XLATE = 2'b01,
    FLT_TYPE  = 2'b10
  } sxl_fault_e;

  typedef struct packed {
    logic [SEC_TAG_W-1:0] pbase;
    logic [1:0]           ap;
    logic [3:0]           dom;
    logic                 c;
    logic                 b;
  } sxl_attr_t;

  function automatic sxl_attr_t sxl_unpack(input logic [31:0] d);
    sxl_attr_t a;
    a.pbase = d[31:20];
    a.ap    = d[11:10];
    a.dom   = d[8:5];
    a.c     = d[3];
    a.b     = d[2];
    return a;
  endfunction

endpackage

// File: rtl/sxl_tlb.sv
module sxl_tlb
  import sxl_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = SEC_TAG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output sxl_attr_t        lk_attr,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  sxl_attr_t        fill_attr,
  input  logic             inv_all,
  input  logic             inv_en,
  input  logic [TAG_W-1:0] inv_tag
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  sxl_attr_t          attr_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] wr_en;
  logic               fill_ok;

  // a fill racing an invalidation of the same section is dropped
  assign fill_ok = fill_en && !inv_all && !(inv_en && (inv_tag == fill_tag));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign match[i] = valid_q[i] && (tag_q[i] == lk_tag);
    assign wr_en[i] = fill_ok && (ptr_q == PTR_W'(i));

    always_ff @(posedge clk) begin
      if (wr_en[i]) begin
        tag_q[i]  <= fill_tag;
        attr_q[i] <= fill_attr;
      end
    end
  end

  always_comb begin
    lk_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_attr = lk_attr | attr_q[i];
    end
  end
  assign lk_hit = |match;

  always_comb begin
    valid_d = valid_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (inv_all) begin
        valid_d[i] = 1'b0;
      end else if (inv_en && valid_q[i] && (tag_q[i] == inv_tag)) begin
        valid_d[i] = 1'b0;
      end
      if (wr_en[i]) valid_d[i] = 1'b1;
    end
    ptr_d = ptr_q;
    if (fill_ok) ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      ptr_q   <= ptr_d;
    end
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R7

  AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0)); // R9

  AST_RACE_DROPS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && inv_en && (inv_tag == fill_tag)) |=> $stable(ptr_q)); // R11

  AST_FILL_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inv_all && !inv_en) |=> valid_q[$past(ptr_q)]); // R8

endmodule

// File: rtl/sxl_walk.sv
module sxl_walk
  import sxl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [31:0]          req_va,
  input  logic                 req_write,
  output logic                 req_ready,
  input  logic [17:0]          ttb_base,
  input  logic                 lk_hit,
  input  sxl_attr_t            lk_attr,
  output logic                 fill_en,
  output logic [SEC_TAG_W-1:0] fill_tag,
  output sxl_attr_t            fill_attr,
  output logic                 mem_rd_req,
  output logic [31:0]          mem_rd_addr,
  input  logic                 mem_rd_valid,
  input  logic [31:0]          mem_rd_data,
  output logic [31:0]          rsp_pa,
  output sxl_attr_t            rsp_attr,
  output sxl_fault_e           rsp_fault,
  output logic                 rsp_write
);

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_RESP} walk_st_e;

  walk_st_e   st_q, st_d;
  logic       load_req, load_rsp;
  logic [31:0] va_q;
  logic        wr_q;
  logic [31:0] addr_q;
  logic [31:0] pa_q, pa_d;
  sxl_attr_t   attr_q, attr_d;
  sxl_fault_e  flt_q, flt_d;
  sxl_attr_t   dec_attr;

  assign dec_attr = sxl_unpack(mem_rd_data);

  always_comb begin
    st_d     = st_q;
    load_req = 1'b0;
    load_rsp = 1'b0;
    pa_d     = '0;
    attr_d   = '0;
    flt_d    = FLT_NONE;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          load_req = 1'b1;
          if (lk_hit) begin
            st_d     = ST_RESP;
            load_rsp = 1'b1;
            pa_d     = {lk_attr.pbase, req_va[SEC_OFF_W-1:0]};
            attr_d   = lk_attr;
          end else begin
            st_d = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        if (mem_rd_valid) begin
          st_d     = ST_RESP;
          load_rsp = 1'b1;
          if (mem_rd_data[1:0] == DESC_SECTION) begin
            pa_d   = {dec_attr.pbase, va_q[SEC_OFF_W-1:0]};
            attr_d = dec_attr;
          end else if (mem_rd_data[1:0] == DESC_EMPTY) begin
            flt_d = FLT_XLATE;
          end else begin
            flt_d = FLT_TYPE;
          end
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (load_req) begin
      va_q   <= req_va;
      wr_q   <= req_write;
      addr_q <= {ttb_base, req_va[31:20], 2'b00};
    end
  end

  always_ff @(posedge clk) begin
    if (load_rsp) begin
      pa_q   <= pa_d;
      attr_q <= attr_d;
      flt_q  <= flt_d;
    end
  end

  assign req_ready   = (st_q == ST_RESP);
  assign mem_rd_req  = (st_q == ST_WALK);
  assign mem_rd_addr = addr_q;
  assign fill_en     = (st_q == ST_WALK) && mem_rd_valid &&
                       (mem_rd_data[1:0] == DESC_SECTION);
  assign fill_tag    = va_q[31:20];
  assign fill_attr   = dec_attr;
  assign rsp_pa      = pa_q;
  assign rsp_attr    = attr_q;
  assign rsp_fault   = flt_q;
  assign rsp_write   = wr_q;

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R6

  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr))); // R6

  AST_DESC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00)); // R2

  AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && req_valid && lk_hit) |=> (req_ready && !mem_rd_req)); // R7

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && rsp_fault != FLT_NONE) |-> (rsp_pa == '0 && rsp_attr == '0)); // R4

endmodule

// File: rtl/sec_xlate.sv
module sec_xlate
  import sxl_pkg::*;
#(
  parameter int TLB_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  input  logic        req_write,
  output logic        req_ready,
  input  logic [17:0] ttb_base,
  input  logic        inv_all,
  input  logic        inv_va_en,
  input  logic [31:0] inv_va,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic [31:0] rsp_pa,
  output logic [3:0]  rsp_domain,
  output logic [1:0]  rsp_ap,
  output logic        rsp_c,
  output logic        rsp_b,
  output logic [1:0]  rsp_fault,
  output logic        rsp_write
);

  logic                 lk_hit;
  sxl_attr_t            lk_attr;
  logic                 fill_en;
  logic [SEC_TAG_W-1:0] fill_tag;
  sxl_attr_t            fill_attr;
  sxl_attr_t            attr;
  sxl_fault_e           fault;

  sxl_tlb #(
    .ENTRIES (TLB_ENTRIES),
    .TAG_W   (SEC_TAG_W)
  ) u_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_tag    (req_va[31:20]),
    .lk_hit    (lk_hit),
    .lk_attr   (lk_attr),
    .fill_en   (fill_en),
    .fill_tag  (fill_tag),
    .fill_attr (fill_attr),
    .inv_all   (inv_all),
    .inv_en    (inv_va_en),
    .inv_tag   (inv_va[31:20])
  );

  sxl_walk u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_va       (req_va),
    .req_write    (req_write),
    .req_ready    (req_ready),
    .ttb_base     (ttb_base),
    .lk_hit       (lk_hit),
    .lk_attr      (lk_attr),
    .fill_en      (fill_en),
    .fill_tag     (fill_tag),
    .fill_attr    (fill_attr),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data),
    .rsp_pa       (rsp_pa),
    .rsp_attr     (attr),
    .rsp_fault    (fault),
    .rsp_write    (rsp_write)
  );

  assign rsp_domain = attr.dom;
  assign rsp_ap     = attr.ap;
  assign rsp_c      = attr.c;
  assign rsp_b      = attr.b;
  assign rsp_fault  = fault;

  AST_READ_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_req) |-> !req_ready); // R6

endmodule

// File: tb/sec_xlate_tb.sv
module sec_xlate_tb;

  logic        clk, rst_n;
  logic        req_valid, req_write, req_ready;
  logic [31:0] req_va;
  logic [17:0] ttb_base;
  logic        inv_all, inv_va_en;
  logic [31:0] inv_va;
  logic        mem_rd_req, mem_rd_valid;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_domain;
  logic [1:0]  rsp_ap, rsp_fault;
  logic        rsp_c, rsp_b, rsp_write;

  int n_chk = 0;
  int n_bad = 0;

  sec_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .req_ready(req_ready), .ttb_base(ttb_base),
    .inv_all(inv_all), .inv_va_en(inv_va_en), .inv_va(inv_va),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_pa(rsp_pa), .rsp_domain(rsp_domain), .rsp_ap(rsp_ap),
    .rsp_c(rsp_c), .rsp_b(rsp_b), .rsp_fault(rsp_fault), .rsp_write(rsp_write)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // row: {va[31:0], desc[31:0], write, latency[3:0]}
  localparam int NROW = 7;
  localparam logic [68:0] TBL [NROW] = '{
    {32'hB000_4000, 32'h3000_0C1E, 1'b0, 4'd0},
    {32'hA000_0054, 32'h5600_0C12, 1'b1, 4'd1},
    {32'h0000_0ABC, 32'h0000_0C1E, 1'b0, 4'd3},
    {32'hB3F1_2345, 32'h33F0_05F6, 1'b1, 4'd7},
    {32'h1230_0000, 32'h0000_0000, 1'b0, 4'd2},
    {32'h4560_0008, 32'h0000_0C11, 1'b0, 4'd0},
    {32'h7FF0_0000, 32'hFFF0_0C13, 1'b1, 4'd5}
  };

  logic        g_walk, g_hold_ok;
  logic [31:0] g_addr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va, input logic wr,
                       input logic [31:0] desc, input int lat, input bit inv_at_fill);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_write = wr;
    g_walk = 1'b0; g_hold_ok = 1'b1; g_addr = '0;
    n = 0;
    while (!req_ready && n < 200) begin
      if (mem_rd_req && !g_walk) begin
        g_walk = 1'b1;
        g_addr = mem_rd_addr;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (!mem_rd_req || mem_rd_addr != g_addr) g_hold_ok = 1'b0;
        end
        mem_rd_valid = 1'b1; mem_rd_data = desc; inv_all = inv_at_fill;
        @(negedge clk);
        mem_rd_valid = 1'b0; mem_rd_data = '0; inv_all = 1'b0;
      end else begin
        @(negedge clk);
      end
      n++;
    end
    chk(req_ready, "R6 ready seen", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b0;
  endtask

  task automatic check_rsp(input logic [31:0] va, input logic wr,
                           input logic [31:0] desc, input string tag);
    logic [31:0] e_pa;
    logic [1:0]  e_flt;
    bit          sec;
    sec   = (desc[1:0] == 2'b10);
    e_pa  = sec ? {desc[31:20], va[19:0]} : 32'd0;
    e_flt = sec ? 2'b00 : (desc[1:0] == 2'b00 ? 2'b01 : 2'b10);
    chk(rsp_pa == e_pa, {tag, " pa"}, rsp_pa, e_pa);
    chk(rsp_fault == e_flt, {tag, " fault"}, {30'd0, rsp_fault}, {30'd0, e_flt});
    chk({rsp_ap, rsp_domain, rsp_c, rsp_b} ==
        (sec ? {desc[11:10], desc[8:5], desc[3], desc[2]} : 8'd0),
        {tag, " attr"}, {24'd0, rsp_ap, rsp_domain, rsp_c, rsp_b},
        sec ? {24'd0, desc[11:10], desc[8:5], desc[3], desc[2]} : 32'd0);
    chk(rsp_write == wr, "R6 write echo", {31'd0, rsp_write}, {31'd0, wr});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_write = 1'b0;
    ttb_base = 18'h0C000; inv_all = 1'b0; inv_va_en = 1'b0; inv_va = '0;
    mem_rd_valid = 1'b0; mem_rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!req_ready, "R1 ready low", {31'd0, req_ready}, 32'd0);
    chk(!mem_rd_req, "R1 read low", {31'd0, mem_rd_req}, 32'd0);

    // vector table: pass 0 fills, pass 1 hits sections and re-walks faults
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < NROW; r++) begin
        logic [31:0] va, desc, ea;
        logic        wr;
        int          lat;
        bit          exp_walk;
        va   = TBL[r][68:37];
        desc = TBL[r][36:5];
        wr   = TBL[r][4];
        lat  = int'(TBL[r][3:0]);
        exp_walk = (p == 0) || (desc[1:0] != 2'b10);
        xlate(va, wr, desc, lat, 1'b0);
        chk(g_walk == exp_walk, (p == 0) ? "R1 first walks" :
            (exp_walk ? "R4 R5 fault not cached" : "R7 hit no read"),
            {31'd0, g_walk}, {31'd0, exp_walk});
        if (g_walk) begin
          ea = {ttb_base, va[31:20], 2'b00};
          chk(g_addr == ea, "R2 desc addr", g_addr, ea);
          chk(g_hold_ok, "R6 walk hold", {31'd0, g_hold_ok}, 32'd1);
        end
        check_rsp(va, wr, desc, desc[1:0] == 2'b10 ? "R3" :
                  (desc[1:0] == 2'b00 ? "R4" : "R5"));
      end
    end

    // R6 one-cycle strobe
    @(negedge clk);
    chk(!req_ready, "R6 ready one cycle", {31'd0, req_ready}, 32'd0);

    // R10 single-entry invalidate by another offset in row 0's section
    @(negedge clk);
    inv_va_en = 1'b1; inv_va = TBL[0][68:37] ^ 32'h0001_2345;
    @(negedge clk);
    inv_va_en = 1'b0;
    xlate(TBL[1][68:37], 1'b0, TBL[1][36:5], 0, 1'b0);
    chk(!g_walk, "R10 other entry hits", {31'd0, g_walk}, 32'd0);
    xlate(TBL[0][68:37], 1'b0, TBL[0][36:5], 2, 1'b0);
    chk(g_walk, "R10 target walks", {31'd0, g_walk}, 32'd1);
    check_rsp(TBL[0][68:37], 1'b0, TBL[0][36:5], "R10");

    // R9 invalidate all
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    xlate(TBL[2][68:37], 1'b0, TBL[2][36:5], 1, 1'b0);
    chk(g_walk, "R9 cleared entry walks", {31'd0, g_walk}, 32'd1);
    xlate(TBL[3][68:37], 1'b1, TBL[3][36:5], 0, 1'b0);
    chk(g_walk, "R9 cleared entry walks", {31'd0, g_walk}, 32'd1);

    // R8 round robin: clear, nine distinct fills, probe
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    for (int s = 0; s < 9; s++) begin
      xlate({12'h400 + 12'(s), 20'h00010}, 1'b0, {12'h800 + 12'(s), 20'h00C1E}, 1, 1'b0);
      chk(g_walk, "R8 fill walks", {31'd0, g_walk}, 32'd1);
    end
    xlate({12'h401, 20'hABCDE}, 1'b0, 32'h0, 0, 1'b0);
    chk(!g_walk, "R8 second fill survives", {31'd0, g_walk}, 32'd0);
    chk(rsp_pa == 32'h801A_BCDE, "R8 survivor pa", rsp_pa, 32'h801A_BCDE);
    xlate({12'h400, 20'h00020}, 1'b0, 32'h8000_0C1E, 1, 1'b0);
    chk(g_walk, "R8 first fill evicted", {31'd0, g_walk}, 32'd1);

    // R11 fill racing inv_all is dropped, answer still returned
    xlate(32'hC000_0100, 1'b1, 32'h9000_0C1E, 1, 1'b1);
    chk(g_walk, "R11 walk", {31'd0, g_walk}, 32'd1);
    check_rsp(32'hC000_0100, 1'b1, 32'h9000_0C1E, "R11");
    xlate(32'hC000_0200, 1'b0, 32'h9000_0C1E, 0, 1'b0);
    chk(g_walk, "R11 dropped fill walks again", {31'd0, g_walk}, 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule